// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects requests from five sources: two external pins, two timer overflows and a serial port. It picks one request to hand to the processor core and gives the core a fixed 16-bit vector address for that source. Software writes an enable mask, a global enable and a per-source priority level, and the block receives them as inputs. Each source has a high or a low level. Inside a level, a fixed order decides which source wins.

The block also decides whether nesting is allowed. It keeps one in-service bit for each level. A high-level request can interrupt a low-level handler. Nothing can interrupt a high-level handler, and a low-level request never interrupts another low-level handler. When the core pulses `ack_i`, the block takes the current winner into service and clears that source's flag if the hardware owns the flag. When the core pulses `reti_i`, the block closes the innermost active level. Each external pin can be set to level-sensitive mode or to falling-edge mode, and in edge mode the event is latched. Instruction fetch and stack handling belong to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source indices are ext0=0, timer0=1, ext1=2, timer1=3, serial=4. While `irq_o` is high, `src_o` holds the winner's index and `vec_o` equals 0x0003 + 8*index (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R2: Among pending, enabled requests of the same level, the lowest index wins.
- R3: A pending request whose `prio_hi_i` bit is 1 wins over every low-level request, whatever its index.
- R4: A source can only request while its `en_i` bit is 1 and `glob_en_i` is 1. A flag that is masked stays pending and wins again once the mask is lifted.
- R5: The serial request is the OR of `ser_rx_done_i` and `ser_tx_done_i`. An acknowledge does not clear it.
- R6: A one-cycle `tmr_ovf_i[k]` pulse sets the flag of timer k. Only an acknowledge of that same timer clears the flag.
- R7: An external input with `ext_edge_i[k]`=1 latches a 1-to-0 change of its pin. An acknowledge of that source clears the latch, and the pin going high again does not. With `ext_edge_i[k]`=0, the request follows the low pin one cycle later, and an acknowledge does not clear it.
- R8: While `in_svc_o[1]`=1, `irq_o` stays low. While only `in_svc_o[0]`=1, only high-level requests raise `irq_o`.
- R9: `ack_i` while `irq_o`=1 sets `in_svc_o[1]` for a high-level winner and `in_svc_o[0]` for a low-level winner. `ack_i` while `irq_o`=0 has no effect.
- R10: `reti_i` clears `in_svc_o[1]` if it is set, and otherwise clears `in_svc_o[0]`.
- R11: After reset, every flag is clear, `in_svc_o`=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 2 | External request pins, active low, bit k = external k |
| ext_edge_i | input | 2 | 1 = falling-edge mode, 0 = level mode, per external |
| tmr_ovf_i | input | 2 | Timer overflow pulses, bit k = timer k |
| ser_rx_done_i | input | 1 | Serial receive-done flag |
| ser_tx_done_i | input | 1 | Serial transmit-done flag |
| en_i | input | 5 | Per-source enable, bit = source index |
| glob_en_i | input | 1 | Global enable |
| prio_hi_i | input | 5 | Per-source level, 1 = high |
| ack_i | input | 1 | Core accepts the current request |
| reti_i | input | 1 | Core returns from a handler |
| irq_o | output | 1 | A request may be taken now |
| vec_o | output | 16 | Vector address of the winner |
| src_o | output | 3 | Index of the winner |
| in_svc_o | output | 2 | In-service bits, [1]=high level, [0]=low level |

## Verification
The hardest state to reach from the ports is a low-level handler in service while several other flags are still pending. Once that state exists, the full set of enable and priority masks must show that only high-level requests get through. The bench reaches it in steps. It latches all five sources first. It then accepts one external edge request at low level, so that flag clears. It then sweeps all 1024 enable and priority patterns against a bench model. After that it accepts a high-level request on top of the low one. This gives both in-service bits set at once, and it unwinds them with two returns.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_EXT    = 2;
  localparam int NUM_TMR    = 2;
  localparam int NUM_SRC    = NUM_EXT + NUM_TMR + 1;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int NUM_LVL    = 2;
  localparam int VEC_W      = 16;
  localparam int VEC_BASE   = 3;
  localparam int VEC_STRIDE = 8;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import prio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_n_i,
  input  logic [NUM_EXT-1:0] ext_edge_i,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  input  logic               ser_rx_done_i,
  input  logic               ser_tx_done_i,
  input  logic [NUM_SRC-2:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  // ext k -> index 2k, timer k -> index 2k+1, serial -> last
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    logic pin_q, flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pin_q  <= 1'b1;
        flag_q <= 1'b0;
      end else begin
        pin_q <= ext_n_i[k];
        if (!ext_edge_i[k])               flag_q <= ~ext_n_i[k];
        else if (pin_q && !ext_n_i[k])    flag_q <= 1'b1;
        else if (clr_i[2*k])              flag_q <= 1'b0;
      end
    end
    assign flag_o[2*k] = flag_q;
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             flag_q <= 1'b0;
      else if (tmr_ovf_i[k])   flag_q <= 1'b1;
      else if (clr_i[2*k+1])   flag_q <= 1'b0;
    end
    assign flag_o[2*k+1] = flag_q;
  end

  assign flag_o[NUM_SRC-1] = ser_rx_done_i | ser_tx_done_i;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] hi_i,
  input  logic [NUM_LVL-1:0] svc_i,
  output logic               valid_o,
  output logic               lvl_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] hi_req, lo_req, pick;
  logic               use_hi, use_lo;

  always_comb begin
    hi_req = req_i & hi_i;
    lo_req = req_i & ~hi_i;
    use_hi = (|hi_req) && !svc_i[1];
    use_lo = !use_hi && (|lo_req) && (svc_i == '0);
    pick   = use_hi ? hi_req : lo_req;
    idx_o  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pick[i]) idx_o = IDX_W'(i);
    end
    valid_o = use_hi | use_lo;
    lvl_o   = use_hi;
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import prio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               lvl_i,
  input  logic               reti_i,
  output logic [NUM_LVL-1:0] svc_o
);
  logic [NUM_LVL-1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti_i) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (accept_i) svc_d[lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) svc_q <= '0;
    else         svc_q <= svc_d;
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_n_i,
  input  logic [NUM_EXT-1:0] ext_edge_i,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  input  logic               ser_rx_done_i,
  input  logic               ser_tx_done_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glob_en_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [IDX_W-1:0]   src_o,
  output logic [NUM_LVL-1:0] in_svc_o
);
  localparam logic [VEC_W-1:0] VBASE = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VSTEP = VEC_W'(VEC_STRIDE);

  logic [NUM_SRC-1:0] flag, pend;
  logic [NUM_SRC-2:0] clr;
  logic               win_valid, win_lvl, accept;
  logic [IDX_W-1:0]   win_idx;

  assign pend   = flag & en_i & {NUM_SRC{glob_en_i}};
  assign accept = ack_i & win_valid;

  // serial has no hardware clear; level-mode externals ignore clr in the bank
  always_comb begin
    for (int i = 0; i < NUM_SRC - 1; i++) clr[i] = accept && (win_idx == IDX_W'(i));
  end

  irq_flag_bank u_flags (
    .clk_i, .rst_ni, .ext_n_i, .ext_edge_i, .tmr_ovf_i,
    .ser_rx_done_i, .ser_tx_done_i,
    .clr_i (clr),
    .flag_o(flag)
  );

  irq_arbiter u_arb (
    .req_i  (pend),
    .hi_i   (prio_hi_i),
    .svc_i  (in_svc_o),
    .valid_o(win_valid),
    .lvl_o  (win_lvl),
    .idx_o  (win_idx)
  );

  irq_svc_track u_svc (
    .clk_i, .rst_ni,
    .accept_i(accept),
    .lvl_i   (win_lvl),
    .reti_i,
    .svc_o   (in_svc_o)
  );

  assign irq_o = win_valid;
  assign src_o = win_idx;
  assign vec_o = VBASE + VEC_W'(win_idx) * VSTEP;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] en_i,
  input logic               glob_en_i,
  input logic [NUM_SRC-1:0] prio_hi_i,
  input logic               ack_i,
  input logic               reti_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [IDX_W-1:0]   src_o,
  input logic [NUM_LVL-1:0] in_svc_o
);
  p_vec_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o == VEC_W'(VEC_BASE) + VEC_W'(src_o) * VEC_W'(VEC_STRIDE)));

  p_glob_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en_i |-> !irq_o);

  p_src_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_i[src_o]);

  p_hi_no_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_svc_o[1] |-> !irq_o);

  p_lo_only_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_svc_o[0] && irq_o) |-> prio_hi_i[src_o]);

  p_ack_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && prio_hi_i[src_o]) |=> in_svc_o[1]);

  p_ack_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !prio_hi_i[src_o]) |=> in_svc_o[0]);

  p_reti_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && in_svc_o[1]) |=> (!in_svc_o[1] && in_svc_o[0] == $past(in_svc_o[0])));

  p_reti_lo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && in_svc_o == 2'b01) |=> (in_svc_o == 2'b00));
endmodule

bind prio_irq_ctrl prio_irq_chk i_chk (
  .clk_i, .rst_ni, .en_i, .glob_en_i, .prio_hi_i, .ack_i, .reti_i,
  .irq_o, .vec_o, .src_o, .in_svc_o
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_n = 2'b11, ext_edge = 2'b11, tmr_ovf = 2'b00;
  logic        rx = 1'b0, tx = 1'b0;
  logic [4:0]  en = '0, prio = '0;
  logic        glob = 1'b0, ack = 1'b0, reti = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic [2:0]  src;
  logic [1:0]  svc;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_n_i(ext_n), .ext_edge_i(ext_edge),
    .tmr_ovf_i(tmr_ovf), .ser_rx_done_i(rx), .ser_tx_done_i(tx),
    .en_i(en), .glob_en_i(glob), .prio_hi_i(prio), .ack_i(ack), .reti_i(reti),
    .irq_o(irq), .vec_o(vec), .src_o(src), .in_svc_o(svc)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int model(logic [4:0] pend, logic [4:0] hi, logic [1:0] s);
    if (!s[1] && (pend & hi) != 0) return lowest(pend & hi);
    if (s == 2'b00 && (pend & ~hi) != 0) return lowest(pend & ~hi);
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0; #1;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0; #1;
  endtask

  task automatic expect_win(string req, int w);
    chk(req, int'(irq), int'(w >= 0));
    if (w >= 0) begin
      chk(req, int'(src), w);
      chk(req, int'(vec), 3 + 8 * w);
    end
  endtask

  task automatic sweep(string req, logic [4:0] flags, logic [1:0] s);
    for (int e = 0; e < 32; e++) begin
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        en = 5'(e); prio = 5'(p);
        #1;
        expect_win(req, model(flags & 5'(e), 5'(p), s));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R11 irq in reset", int'(irq), 0);
    chk("R11 svc in reset", int'(svc), 0);
    rst_n = 1'b1;
    en = 5'h1f; glob = 1'b1;
    tick(); #1;
    chk("R11 irq after reset", int'(irq), 0);
    chk("R11 svc after reset", int'(svc), 0);

    // latch every source
    ext_n = 2'b00; tmr_ovf = 2'b11; rx = 1'b1;
    tick(); tmr_ovf = 2'b00;
    tick();
    sweep("R1 R2 R3 R4 sweep idle", 5'h1f, 2'b00);

    @(negedge clk); en = 5'h1f; glob = 1'b0; #1;
    chk("R4 global off", int'(irq), 0);
    glob = 1'b1;

    en = 5'h00; #1;
    chk("R4 all masked", int'(irq), 0);
    pulse_ack();
    chk("R9 ack ignored svc", int'(svc), 0);
    en = 5'h1f; prio = 5'h00; #1;
    expect_win("R9 R4 masked flag kept", 0);

    pulse_ack();
    chk("R9 lo accept", int'(svc), 1);
    prio = 5'h01; #1;
    chk("R7 edge flag cleared by ack", int'(irq), 0);
    sweep("R8 sweep lo in service", 5'b11110, 2'b01);

    @(negedge clk); en = 5'h1f; prio = 5'b00100; #1;
    expect_win("R8 hi preempts lo", 2);
    pulse_ack();
    chk("R9 hi accept", int'(svc), 3);
    prio = 5'h1f; #1;
    chk("R8 hi blocks all", int'(irq), 0);
    pulse_reti();
    chk("R10 reti hi first", int'(svc), 1);
    pulse_reti();
    chk("R10 reti lo", int'(svc), 0);

    prio = 5'h00; #1;
    expect_win("R6 t0 pending", 1);
    pulse_ack(); pulse_reti();
    expect_win("R6 t0 cleared t1 kept", 3);
    pulse_ack(); pulse_reti();
    expect_win("R5 serial", 4);
    pulse_ack(); pulse_reti();
    expect_win("R5 serial not cleared", 4);
    rx = 1'b0; tx = 1'b1; #1;
    expect_win("R5 tx alone", 4);
    tx = 1'b0; #1;
    chk("R5 both flags low", int'(irq), 0);

    ext_edge = 2'b00; tick(); #1;
    expect_win("R7 level low pin", 0);
    pulse_ack(); pulse_reti();
    expect_win("R7 level not cleared", 0);
    ext_n = 2'b11; tick(); #1;
    chk("R7 level pin high", int'(irq), 0);

    ext_edge = 2'b11; ext_n = 2'b01; tick(); #1;
    expect_win("R7 edge latched", 2);
    ext_n = 2'b11; tick(); #1;
    expect_win("R7 edge held after pin high", 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule